// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-serviced watchdog. A 9-bit two's-complement count goes down by one on each timebase tick. The tick comes from a prescaler that counts system clocks. Software keeps the system alive by rewriting the count through a 16-bit register interface.

In the default mode the count is allowed to go below zero. Landing on zero gives a one-clock non-maskable interrupt warning. Landing on -16 gives a one-clock system reset request, and the count is then reloaded with 255. A set-only mode bit changes this behaviour: in that mode any landing on zero or below requests the reset at once, and no warning is given. The mode bit also stops software from freezing the count.

Reload writes are filtered so that software running out of control is unlikely to service the timer by accident. A debug-halt input always holds the count, in either mode.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, both registers read 0x0000, and `nmiPulse` and `wdtRstPulse` are low.
- R2: A tick occurs every `PRESCALE` clocks, counted from reset. The first tick falls on the `PRESCALE`-th rising edge after reset is released. Each tick that is not held lowers the count by one, modulo 512 (for example 1, 0, 0x1FF).
- R3: A write to byte offset 0x0 reloads the count only when write-data bits 15..9 are all zero. The count then becomes {0, data[7:0]}, and data bit 8 is ignored. Any other write pattern leaves the count unchanged.
- R4: Reading offset 0x0 returns the live 9-bit count in bits 8..0, with zeros above. Reading offset 0x2 returns the mode bit in bit 0, with zeros above. Reads of offsets 0x1 and 0x3 return 0.
- R5: In mode 0, `nmiPulse` is high for exactly one clock when a decrement lands on 0. Holding at 0 does not repeat the pulse.
- R6: In mode 0, a decrement that lands on 0x1F0 (-16) gives a one-clock `wdtRstPulse` and sets the count to 0x0FF.
- R7: In mode 1, a decrement that lands on 0 or on a negative value gives a one-clock `wdtRstPulse` and sets the count to 0x0FF. `nmiPulse` stays low.
- R8: Writing a 1 to bit 0 at offset 0x2 sets the mode bit, and writing a 0 there has no effect. The mode bit is cleared by `swRst` or by a watchdog reset event, and either clear takes priority over a set in the same cycle.
- R9: In mode 0, a `freezeSet` strobe stops the decrements and a `freezeClr` strobe resumes them. If both strobes arrive together, the clear wins.
- R10: In mode 1, `freezeSet` is ignored, and a freeze that was already in place stops taking effect.
- R11: While `dbgHalt` is high, the count does not decrement, in either mode.
- R12: A tick that falls in the same cycle as an accepted reload is discarded. The count takes the reload value, and the next decrement comes one full tick period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Byte offset: 0x0 = count, 0x2 = mode |
| regWr | input | 1 | Write strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| freezeSet | input | 1 | Freeze strobe |
| freezeClr | input | 1 | Unfreeze strobe |
| dbgHalt | input | 1 | Processor halted in debug |
| swRst | input | 1 | Software reset; clears the mode bit |
| nmiPulse | output | 1 | One-clock non-maskable interrupt warning |
| wdtRstPulse | output | 1 | One-clock system reset request |

## Verification
The count can be read at offset 0x0 on every clock, so a wrong count, a wrong reload or a wrong filter decision shows up in the read data on the very next cycle. A wrong freeze flag or a wrong prescaler phase stays hidden until the next tick, which is at most `PRESCALE` clocks later. A wrong mode bit shows up at once through offset 0x2. Its effect on the thresholds appears as a missing or misplaced pulse on the first decrement that reaches zero. For these reasons the bench compares the read data and both pulse outputs against its own model on every clock, while it walks through reload filtering, both threshold paths, the freeze strobes and debug halt.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
  localparam int CNT_W  = 9;
  localparam int LOAD_W = 8;
  localparam int REG_W  = 16;
  localparam int FILT_LSB = 9;
  localparam logic [CNT_W-1:0] RST_LEVEL   = 9'h1F0;
  localparam logic [CNT_W-1:0] AFTER_RESET = 9'h0FF;

  typedef struct packed {
    logic              load;
    logic [LOAD_W-1:0] loadVal;
    logic              dec;
    logic              strictMode;
  } wdtCmd_t;
endpackage

// File: rtl/twostage_wdt_ctrl.sv
module twostage_wdt_ctrl
  import twostage_wdt_pkg::*;
#(
  parameter int PRESCALE = 2048,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              freezeSet,
  input  logic              freezeClr,
  input  logic              dbgHalt,
  input  logic              swRst,
  input  logic              rstFire,
  input  logic [CNT_W-1:0]  cnt,
  output wdtCmd_t           cmd,
  output logic [REG_W-1:0]  regRdata
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [ADDR_W-1:0] VAL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(2);

  logic [PRE_W-1:0] presc;
  logic frozen, modeBit, tick, hold, loadOk, valSel, ctlSel;
  logic unusedData;

  assign unusedData = regWdata[LOAD_W];
  assign valSel = (regAddr == VAL_OFS);
  assign ctlSel = (regAddr == CTL_OFS);
  assign loadOk = regWr & valSel & (regWdata[REG_W-1:FILT_LSB] == '0);
  assign tick = (presc == PRE_LAST);
  assign hold = dbgHalt | (frozen & ~modeBit);

  always_comb begin
    cmd.load = loadOk;
    cmd.loadVal = regWdata[LOAD_W-1:0];
    cmd.dec = tick & ~hold & ~loadOk;
    cmd.strictMode = modeBit;
  end

  always_comb begin
    regRdata = '0;
    if (valSel) regRdata[CNT_W-1:0] = cnt;
    else if (ctlSel) regRdata[0] = modeBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      frozen <= 1'b0;
      modeBit <= 1'b0;
    end else begin
      presc <= tick ? '0 : presc + 1'b1;
      if (modeBit || freezeClr) frozen <= 1'b0;
      else if (freezeSet) frozen <= 1'b1;
      if (swRst || rstFire) modeBit <= 1'b0;
      else if (regWr && ctlSel && regWdata[0]) modeBit <= 1'b1;
    end
  end
endmodule

// File: rtl/twostage_wdt_dp.sv
module twostage_wdt_dp
  import twostage_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wdtCmd_t          cmd,
  output logic [CNT_W-1:0] cnt,
  output logic             nmiPulse,
  output logic             rstPulse,
  output logic             rstFire
);
  logic [CNT_W-1:0] nextCnt;
  logic landNonPos, nmiFire;

  assign nextCnt = cnt - 1'b1;
  assign landNonPos = nextCnt[CNT_W-1] | (nextCnt == '0);
  assign rstFire = cmd.dec & (cmd.strictMode ? landNonPos : (nextCnt == RST_LEVEL));
  assign nmiFire = cmd.dec & ~cmd.strictMode & (nextCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      nmiPulse <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      if (cmd.load) cnt <= {1'b0, cmd.loadVal};
      else if (rstFire) cnt <= AFTER_RESET;
      else if (cmd.dec) cnt <= nextCnt;
      nmiPulse <= nmiFire;
      rstPulse <= rstFire;
    end
  end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twostage_wdt_pkg::*;
#(
  parameter int PRESCALE = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        freezeSet,
  input  logic        freezeClr,
  input  logic        dbgHalt,
  input  logic        swRst,
  output logic        nmiPulse,
  output logic        wdtRstPulse
);
  wdtCmd_t cmd;
  logic [CNT_W-1:0] cnt;
  logic rstFire;

  twostage_wdt_ctrl #(.PRESCALE(PRESCALE), .ADDR_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .freezeSet(freezeSet), .freezeClr(freezeClr),
    .dbgHalt(dbgHalt), .swRst(swRst), .rstFire(rstFire), .cnt(cnt),
    .cmd(cmd), .regRdata(regRdata)
  );

  twostage_wdt_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cnt(cnt),
    .nmiPulse(nmiPulse), .rstPulse(wdtRstPulse), .rstFire(rstFire)
  );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regAddr,
  input logic        regWr,
  input logic [15:0] regRdata,
  input logic        dbgHalt,
  input logic        nmiPulse,
  input logic        wdtRstPulse
);
  p_nmi_at_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPulse && regAddr == 2'b00) |-> (regRdata == 16'h0000));

  p_nmi_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> !nmiPulse);

  p_rst_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wdtRstPulse && regAddr == 2'b00) |-> (regRdata == 16'h00FF));

  p_rst_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstPulse |=> !wdtRstPulse);

  p_pulses_apart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiPulse && wdtRstPulse));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'b00) |-> (regRdata[15:9] == 7'h00));

  p_halt_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && !regWr && regAddr == 2'b00) |=> (regAddr != 2'b00 || $stable(regRdata)));
endmodule

bind twostage_wdt twostage_wdt_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
  .regRdata(regRdata), .dbgHalt(dbgHalt), .nmiPulse(nmiPulse),
  .wdtRstPulse(wdtRstPulse)
);

// File: tb/twostage_wdt_test.sv
`timescale 1ns/1ps
module twostage_wdt_test;
  localparam int PRE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = 2'b00;
  logic regWr = 1'b0;
  logic [15:0] regWdata = 16'h0000;
  logic freezeSet = 1'b0, freezeClr = 1'b0, dbgHalt = 1'b0, swRst = 1'b0;
  logic [15:0] regRdata;
  logic nmiPulse, wdtRstPulse;

  int checks = 0, errors = 0, cyc = 0;
  int nmiSeen = 0, rstSeen = 0;
  string curReq = "R1";
  bit finished = 0;

  // behavioural model state
  int mCnt = 0, mPresc = 0;
  bit mMode = 0, mFrozen = 0, mNmi = 0, mRst = 0;

  always #2.5 clk = ~clk;

  twostage_wdt #(.PRESCALE(PRE)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .freezeSet(freezeSet),
    .freezeClr(freezeClr), .dbgHalt(dbgHalt), .swRst(swRst),
    .nmiPulse(nmiPulse), .wdtRstPulse(wdtRstPulse)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mPresc = 0; mMode = 0; mFrozen = 0; mNmi = 0; mRst = 0;
    end else begin
      bit tick, held, ev;
      int n;
      tick = (mPresc == PRE - 1);
      mPresc = tick ? 0 : mPresc + 1;
      held = dbgHalt || (mFrozen && !mMode);
      mNmi = 0; ev = 0;
      if (regWr && regAddr == 2'd0 && regWdata[15:9] == 7'd0) mCnt = regWdata[7:0];
      else if (tick && !held) begin
        n = mCnt - 1;
        if (!mMode) begin
          if (n == 0) mNmi = 1;
          if (n == -16) begin ev = 1; n = 255; end
        end else if (n <= 0) begin ev = 1; n = 255; end
        mCnt = n;
      end
      mRst = ev;
      if (mMode || freezeClr) mFrozen = 0;
      else if (freezeSet) mFrozen = 1;
      if (swRst || ev) mMode = 0;
      else if (regWr && regAddr == 2'd2 && regWdata[0]) mMode = 1;
    end
  end

  function automatic logic [15:0] expRead(logic [1:0] a);
    logic [8:0] v;
    v = mCnt[8:0];
    if (a == 2'd0) return {7'd0, v};
    if (a == 2'd2) return {15'd0, mMode};
    return 16'h0000;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!finished) begin
      check(curReq, regRdata, expRead(regAddr));
      check(curReq, {15'd0, nmiPulse}, {15'd0, mNmi});
      check(curReq, {15'd0, wdtRstPulse}, {15'd0, mRst});
      if (nmiPulse) nmiSeen++;
      if (wdtRstPulse) rstSeen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic ticks(int n);
    repeat (n * PRE) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1.5;
    d = regRdata;
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  initial begin
    logic [15:0] v, v0;
    // R1 reset state
    repeat (3) @(negedge clk);
    #1.5;
    check("R1", regRdata, 16'h0000);
    check("R1", {14'd0, nmiPulse, wdtRstPulse}, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    rd(2'd2, v); check("R1", v, 16'h0000);
    rd(2'd0, v); check("R1", v, 16'h0000);

    // R2 counting through zero into negatives
    curReq = "R2";
    ticks(3);

    // R3 reload filter
    curReq = "R3";
    wr(2'd0, 16'h0003); #1.5; check("R3", regRdata, 16'h0003);
    wr(2'd0, 16'h0205); #1.5; check("R3", regRdata, expRead(2'd0));
    wr(2'd0, 16'h8044);
    wr(2'd0, 16'h0105); #1.5; check("R3", regRdata, 16'h0005);

    // R5 / R6 mode 0 thresholds
    curReq = "R5"; nmiSeen = 0; rstSeen = 0;
    ticks(8);
    curReq = "R6";
    ticks(18);
    check("R5", nmiSeen[15:0], 16'd1);
    check("R6", rstSeen[15:0], 16'd1);

    // R4 read map
    curReq = "R4";
    rd(2'd1, v); check("R4", v, 16'h0000);
    rd(2'd3, v); check("R4", v, 16'h0000);
    rd(2'd2, v); check("R4", v, 16'h0000);

    // R12 reload coincident with tick
    curReq = "R12";
    @(negedge clk); regAddr = 2'd0;
    while (mPresc != PRE - 1) @(negedge clk);
    regAddr = 2'd0; regWdata = 16'h0040; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
    #1.5; check("R12", regRdata, 16'h0040);
    repeat (PRE - 1) @(negedge clk);
    #1.5; check("R12", regRdata, 16'h0040);

    // R9 freeze in mode 0
    curReq = "R9";
    strobe(freezeSet);
    #1.5; v0 = regRdata;
    ticks(5); #1.5; check("R9", regRdata, v0);
    @(negedge clk); freezeSet = 1'b1; freezeClr = 1'b1;
    @(negedge clk); freezeSet = 1'b0; freezeClr = 1'b0;
    ticks(3);
    strobe(freezeSet);
    ticks(2);
    strobe(freezeClr);
    ticks(3);

    // R11 debug halt in mode 0
    curReq = "R11";
    @(negedge clk); dbgHalt = 1'b1;
    #1.5; v0 = regRdata;
    ticks(5); #1.5; check("R11", regRdata, v0);
    @(negedge clk); dbgHalt = 1'b0;
    ticks(2);

    // R10 freeze in place, then mode 1 cancels it
    curReq = "R10";
    strobe(freezeSet);
    ticks(2);
    wr(2'd2, 16'h0001);
    ticks(4);

    // R8 mode bit is set-only
    curReq = "R8";
    wr(2'd2, 16'h0000);
    rd(2'd2, v); check("R8", v, 16'h0001);
    @(negedge clk); regAddr = 2'd0;
    strobe(freezeSet);
    curReq = "R10";
    #1.5; v0 = regRdata;
    ticks(3); #1.5;
    checks++;
    if (regRdata == v0) begin
      errors++;
      $display("FAIL R10: actual 0x%04h expected change from 0x%04h", regRdata, v0);
    end

    // R11 debug halt in mode 1
    curReq = "R11";
    @(negedge clk); dbgHalt = 1'b1;
    #1.5; v0 = regRdata;
    ticks(4); #1.5; check("R11", regRdata, v0);
    @(negedge clk); dbgHalt = 1'b0;

    // R7 reset at zero in mode 1, mode cleared by the event
    curReq = "R7"; nmiSeen = 0; rstSeen = 0;
    wr(2'd0, 16'h0003);
    ticks(5);
    check("R7", nmiSeen[15:0], 16'd0);
    check("R7", rstSeen[15:0], 16'd1);
    rd(2'd2, v); check("R8", v, 16'h0000);

    // R7 mode set while negative
    @(negedge clk); regAddr = 2'd0;
    wr(2'd0, 16'h0002);
    ticks(3);
    nmiSeen = 0; rstSeen = 0;
    wr(2'd2, 16'h0001);
    ticks(2);
    check("R7", rstSeen[15:0], 16'd1);

    // R8 software reset clears mode, clear wins over set
    curReq = "R8";
    wr(2'd2, 16'h0001);
    strobe(swRst);
    rd(2'd2, v); check("R8", v, 16'h0000);
    @(negedge clk); regAddr = 2'd2; regWdata = 16'h0001; regWr = 1'b1; swRst = 1'b1;
    @(negedge clk); regWr = 1'b0; swRst = 1'b0;
    #1.5; check("R8", regRdata, 16'h0000);
    @(negedge clk); regAddr = 2'd0;
    ticks(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule